// File: doc/BRIEF.md
# Expanding-Opcode Instruction Decoder with Operand Fetch

This block sits between an instruction fetch stage and an execution stage. It takes one 32-bit instruction word at a time through a valid/ready handshake. It sorts the word into one of three operand classes using an expanding opcode. It then resolves the effective operand by reading a synchronous memory port zero, one or two times. The result is the operation code, the operand class, the operand value and a sticky halt flag. The result is held with a valid flag until the consumer acknowledges it.

The three most significant bits are the primary opcode. When they are all ones, the next bit extends the opcode. A clear extension bit gives a one-operand instruction, and a set extension bit gives a no-operand instruction. Two-operand words carry a 2-bit addressing mode and a 27-bit field. The index register used by indexed mode is supplied on an input port.

Top module: `instr_operand_fetch`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, halted is 0 and mem_rd_en is 0.
- R2: A word whose bits 31:29 are 000 to 110 is two-operand: out_class is 2'b00 and out_opc equals bits 31:29.
- R3: A word whose bits 31:28 are 1110 is one-operand: out_class is 2'b01, out_opc equals bits 27:25, and the operand is read in direct mode from the zero-extended bits 24:0. Bits 28:27 play no part as a mode.
- R4: A word whose bits 31:28 are 1111 is no-operand: out_class is 2'b10, out_opc equals bits 27:25, out_operand is 0, no memory read is issued, and out_valid rises 2 cycles after the accepting edge.
- R5: For a two-operand word, bits 28:27 = 11 selects immediate mode. The operand is bits 26:0 zero-extended. No memory read is issued, and out_valid rises 2 cycles after the accepting edge.
- R6: Bits 28:27 = 00 selects direct mode. One read is made at the zero-extended bits 26:0, issued in the cycle after acceptance. Read data returns one cycle after mem_rd_en, and that data becomes the operand. out_valid rises 3 cycles after acceptance.
- R7: Bits 28:27 = 10 selects indexed mode. The read address is the zero-extended field plus index_val, modulo 2^32. Otherwise the timing is as in R6.
- R8: Bits 28:27 = 01 selects indirect mode. The first read is at the field. The second read, in the next cycle, is at the word the first read returned. The second word is the operand, and out_valid rises 4 cycles after acceptance. No instruction causes more than two reads.
- R9: in_ready is high only when the unit is idle and not halted. A word is taken only on a clock edge with in_valid and in_ready both high. With in_valid low, nothing starts.
- R10: While out_valid is high and out_ack is low, out_operand, out_class and out_opc hold their values. After an edge with out_ack high, out_valid is 0 and in_ready is 1 (unless halted).
- R11: The word 32'hF000_0000 exactly sets halted when its result is presented. halted then stays high and in_ready stays low until reset. Other 1111-prefix words do not halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit can take a word |
| in_word | input | 32 | Instruction word |
| index_val | input | 32 | Index register contents for indexed mode |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Memory read address |
| mem_rd_data | input | 32 | Read data, valid one cycle after the request |
| out_valid | output | 1 | Decoded result available |
| out_ack | input | 1 | Consumer takes the result |
| out_class | output | 2 | 00 two-operand, 01 one-operand, 10 no-operand |
| out_opc | output | 3 | Decoded operation code |
| out_operand | output | 32 | Resolved operand value |
| halted | output | 1 | Sticky halt flag |

## Verification
The bench targets the opcode boundary between 110 and 111. It uses one-operand words whose bits 28:27 would read as indirect mode if misdecoded, so a decoder that ignores the extension bit issues two reads and returns the wrong operand. An indexed address that wraps past 2^32 catches a truncated adder. An indirect fetch catches a sequencer that reuses the field instead of the returned pointer, or that miscounts latency by a cycle. It also checks that a no-operand word with nonzero low bits does not halt, and that a real halt keeps the input closed while further words are offered.

// File: rtl/ifd_pkg.sv
// Shared encodings for the expanding-opcode decoder and its sequencer.
// Assumes a 2-bit addressing-mode field.
package ifd_pkg;
    typedef enum logic [1:0] {
        MODE_DIRECT    = 2'b00,
        MODE_INDIRECT  = 2'b01,
        MODE_INDEXED   = 2'b10,
        MODE_IMMEDIATE = 2'b11
    } amode_e;

    typedef enum logic [1:0] {
        CLS_TWO  = 2'b00,
        CLS_ONE  = 2'b01,
        CLS_NONE = 2'b10
    } iclass_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_ADDR_READ,
        ST_DATA_READ,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/ifd_classify.sv
// Combinational decoder for the expanding opcode.
// It gives the operand class, the operation code and the effective mode.
// It also gives the value used as the immediate operand or the first read address,
// and whether the word is the exact halt encoding.
// Assumes MODE_W matches the 2-bit mode type in ifd_pkg.
module ifd_classify
    import ifd_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int OPC_W  = 3,
    parameter int MODE_W = 2
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [WORD_W-1:0] index_i,
    output iclass_e           cls_o,
    output logic [OPC_W-1:0]  opc_o,
    output amode_e            mode_o,
    output logic [WORD_W-1:0] value_o,
    output logic              halt_o
);
    localparam int TWO_FIELD_W = WORD_W - OPC_W - MODE_W;
    localparam int PREFIX_W    = OPC_W + 1;
    localparam int ONE_FIELD_W = WORD_W - PREFIX_W - OPC_W;

    logic [OPC_W-1:0]  top;
    logic              ext_bit;
    logic [WORD_W-1:0] field;

    // Decode the class, the opcode and the mode, then form the effective value.
    always_comb begin
        top     = word_i[WORD_W-1 -: OPC_W];
        ext_bit = word_i[WORD_W-1-OPC_W];
        cls_o   = CLS_TWO;
        opc_o   = top;
        mode_o  = amode_e'(word_i[TWO_FIELD_W +: MODE_W]);
        field   = WORD_W'(word_i[TWO_FIELD_W-1:0]);
        halt_o  = 1'b0;
        if (&top) begin
            opc_o = word_i[ONE_FIELD_W +: OPC_W];
            if (!ext_bit) begin
                cls_o  = CLS_ONE;
                mode_o = MODE_DIRECT;
                field  = WORD_W'(word_i[ONE_FIELD_W-1:0]);
            end else begin
                cls_o  = CLS_NONE;
                mode_o = MODE_IMMEDIATE;
                field  = '0;
                halt_o = (word_i[WORD_W-PREFIX_W-1:0] == '0);
            end
        end
        value_o = (mode_o == MODE_INDEXED) ? field + index_i : field;
    end
endmodule

// File: rtl/ifd_sequencer.sv
// Operand-fetch sequencer: handshake, per-mode memory read sequence,
// result handshake and the sticky halt flag.
// Assumes memory read data returns one cycle after the request.
module ifd_sequencer
    import ifd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    in_valid_i,
    input  iclass_e cls_i,
    input  amode_e  mode_i,
    input  logic    halt_i,
    input  logic    out_ack_i,
    output logic    in_ready_o,
    output logic    load_instr_o,
    output logic    rd_en_o,
    output logic    rd_sel_mem_o,
    output logic    load_res_o,
    output logic    res_sel_mem_o,
    output logic    out_valid_o,
    output logic    halted_o
);
    seq_state_e state_q, state_d;
    logic       halted_q, set_halt;

    // State and sticky-halt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            halted_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (set_halt) halted_q <= 1'b1;
        end
    end

    // Next-state logic and per-state control strobes.
    always_comb begin
        state_d       = state_q;
        load_instr_o  = 1'b0;
        rd_en_o       = 1'b0;
        rd_sel_mem_o  = 1'b0;
        load_res_o    = 1'b0;
        res_sel_mem_o = 1'b0;
        set_halt      = 1'b0;
        case (state_q)
            ST_IDLE: if (in_valid_i && !halted_q) begin
                load_instr_o = 1'b1;
                state_d      = ST_DECODE;
            end
            ST_DECODE: begin
                if (cls_i == CLS_NONE || mode_i == MODE_IMMEDIATE) begin
                    load_res_o = 1'b1;
                    set_halt   = (cls_i == CLS_NONE) && halt_i;
                    state_d    = ST_DONE;
                end else begin
                    rd_en_o = 1'b1;
                    state_d = (mode_i == MODE_INDIRECT) ? ST_ADDR_READ : ST_DATA_READ;
                end
            end
            ST_ADDR_READ: begin
                rd_en_o      = 1'b1;
                rd_sel_mem_o = 1'b1;
                state_d      = ST_DATA_READ;
            end
            ST_DATA_READ: begin
                load_res_o    = 1'b1;
                res_sel_mem_o = 1'b1;
                state_d       = ST_DONE;
            end
            ST_DONE: if (out_ack_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign in_ready_o  = (state_q == ST_IDLE) && !halted_q;
    assign out_valid_o = (state_q == ST_DONE);
    assign halted_o    = halted_q;
endmodule

// File: rtl/ifd_capture.sv
// Holding registers for the accepted instruction word and the resolved operand.
// Both change only on their load strobes, so outputs stay stable between loads.
module ifd_capture #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_instr_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              load_res_i,
    input  logic              res_sel_mem_i,
    input  logic [WORD_W-1:0] value_i,
    input  logic [WORD_W-1:0] mem_data_i,
    output logic [WORD_W-1:0] instr_o,
    output logic [WORD_W-1:0] operand_o
);
    // Capture the instruction on acceptance and the operand on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_o   <= '0;
            operand_o <= '0;
        end else begin
            if (load_instr_i) instr_o <= word_i;
            if (load_res_i) operand_o <= res_sel_mem_i ? mem_data_i : value_i;
        end
    end
endmodule

// File: rtl/instr_operand_fetch.sv
// Top level: expanding-opcode decode with multi-cycle operand fetch.
// Assumes a synchronous memory port with one cycle of read latency.
// Assumes index_val is stable while a word is being decoded.
module instr_operand_fetch
    import ifd_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int OPC_W  = 3,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic [WORD_W-1:0] index_val,
    output logic              mem_rd_en,
    output logic [WORD_W-1:0] mem_rd_addr,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              out_valid,
    input  logic              out_ack,
    output logic [1:0]        out_class,
    output logic [OPC_W-1:0]  out_opc,
    output logic [WORD_W-1:0] out_operand,
    output logic              halted
);
    logic [WORD_W-1:0] instr_q, value;
    iclass_e           cls;
    amode_e            mode;
    logic              halt_word, load_instr, rd_sel_mem, load_res, res_sel_mem;

    ifd_classify #(.WORD_W(WORD_W), .OPC_W(OPC_W), .MODE_W(MODE_W)) u_classify (
        .word_i (instr_q),
        .index_i(index_val),
        .cls_o  (cls),
        .opc_o  (out_opc),
        .mode_o (mode),
        .value_o(value),
        .halt_o (halt_word)
    );

    ifd_sequencer u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid_i   (in_valid),
        .cls_i        (cls),
        .mode_i       (mode),
        .halt_i       (halt_word),
        .out_ack_i    (out_ack),
        .in_ready_o   (in_ready),
        .load_instr_o (load_instr),
        .rd_en_o      (mem_rd_en),
        .rd_sel_mem_o (rd_sel_mem),
        .load_res_o   (load_res),
        .res_sel_mem_o(res_sel_mem),
        .out_valid_o  (out_valid),
        .halted_o     (halted)
    );

    ifd_capture #(.WORD_W(WORD_W)) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_instr_i (load_instr),
        .word_i       (in_word),
        .load_res_i   (load_res),
        .res_sel_mem_i(res_sel_mem),
        .value_i      (value),
        .mem_data_i   (mem_rd_data),
        .instr_o      (instr_q),
        .operand_o    (out_operand)
    );

    // Second indirect read is addressed by the pointer just returned.
    assign mem_rd_addr = rd_sel_mem ? mem_rd_data : value;
    assign out_class   = cls;
endmodule

// File: rtl/ifd_checker.sv
// Protocol and sequencing properties for instr_operand_fetch, attached by bind.
module ifd_checker #(
    parameter int WORD_W = 32,
    parameter int OPC_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ack,
    input logic [1:0]        out_class,
    input logic [OPC_W-1:0]  out_opc,
    input logic [WORD_W-1:0] out_operand,
    input logic              mem_rd_en,
    input logic              halted
);
    logic [1:0] rd_cnt;

    // Count the reads made since the last accepted word (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) rd_cnt <= '0;
        else if (in_valid && in_ready) rd_cnt <= '0;
        else if (mem_rd_en && rd_cnt != 2'd3) rd_cnt <= rd_cnt + 2'd1;
    end

    AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!out_valid && !mem_rd_en)); // R9
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R11
    AST_HALT_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !in_ready); // R11
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ack) |=> (out_valid && $stable(out_operand)
                                     && $stable(out_class) && $stable(out_opc))); // R10
    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ack) |=> !out_valid); // R10
    AST_READ_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt <= 2'd2); // R8
    AST_NO_OPERAND_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == 2'b10) |-> (rd_cnt == 2'd0)); // R4
endmodule

bind instr_operand_fetch ifd_checker #(.WORD_W(WORD_W), .OPC_W(OPC_W)) u_chk (.*);

// File: tb/instr_operand_fetch_tb.sv
// Self-checking bench with a behavioural reference model and a behavioural memory.
module instr_operand_fetch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_ready;
    logic [31:0] in_word = '0, index_val = '0;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr, mem_rd_data;
    logic        out_valid, out_ack = 1'b0;
    logic [1:0]  out_class;
    logic [2:0]  out_opc;
    logic [31:0] out_operand;
    logic        halted;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    instr_operand_fetch u_dut (.*);

    // Memory contents are a fixed function of the address.
    function automatic logic [31:0] memf(input logic [31:0] a);
        return {a[15:0] ^ 16'hC35A, a[15:0] + 16'h1111};
    endfunction

    // Behavioural memory with one cycle of read latency.
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= memf(mem_rd_addr);
    initial mem_rd_data = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // Offer one word, track reads cycle by cycle, then verify the result, hold and ack.
    task automatic run_instr(input logic [31:0] w, input string tag);
        logic [1:0]  e_cls;
        logic [2:0]  e_opc;
        logic [31:0] e_op, a0, a1;
        int          e_lat, e_nrd, nrd, lat;
        bit          e_halt, bad_ready;
        logic [31:0] rd_addr [2];
        a0 = '0; a1 = '0; e_halt = 0; e_nrd = 0;
        if (w[31:29] != 3'b111) begin
            e_cls = 2'b00; e_opc = w[31:29];
            a0 = {5'b0, w[26:0]};
            case (w[28:27])
                2'b11: begin e_op = a0; e_lat = 2; end
                2'b00: begin e_nrd = 1; e_op = memf(a0); e_lat = 3; end
                2'b10: begin a0 = a0 + index_val; e_nrd = 1; e_op = memf(a0); e_lat = 3; end
                default: begin a1 = memf(a0); e_nrd = 2; e_op = memf(a1); e_lat = 4; end
            endcase
        end else if (!w[28]) begin
            e_cls = 2'b01; e_opc = w[27:25];
            a0 = {7'b0, w[24:0]}; e_nrd = 1; e_op = memf(a0); e_lat = 3;
        end else begin
            e_cls = 2'b10; e_opc = w[27:25]; e_op = '0; e_lat = 2;
            e_halt = (w[27:0] == 28'h0);
        end
        @(negedge clk);
        chk(in_ready == 1'b1, "R9", "ready before offer", 32'(in_ready), 32'd1);
        in_word = w; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        nrd = 0; lat = 0; bad_ready = 0; rd_addr[0] = '0; rd_addr[1] = '0;
        for (int c = 1; c <= 8; c++) begin
            if (mem_rd_en) begin
                if (nrd < 2) rd_addr[nrd] = mem_rd_addr;
                nrd++;
            end
            if (in_ready) bad_ready = 1;
            if (out_valid) begin lat = c; break; end
            @(negedge clk);
        end
        chk(!bad_ready, "R9", "ready while busy", 32'(bad_ready), 32'd0);
        chk(lat == e_lat, tag, "latency", 32'(lat), 32'(e_lat));
        chk(nrd == e_nrd, tag, "read count", 32'(nrd), 32'(e_nrd));
        if (e_nrd >= 1) chk(rd_addr[0] == a0, tag, "first read addr", rd_addr[0], a0);
        if (e_nrd == 2) chk(rd_addr[1] == a1, tag, "second read addr", rd_addr[1], a1);
        chk(out_class == e_cls, tag, "class", 32'(out_class), 32'(e_cls));
        chk(out_opc == e_opc, tag, "opcode", 32'(out_opc), 32'(e_opc));
        chk(out_operand == e_op, tag, "operand", out_operand, e_op);
        chk(halted == e_halt, "R11", "halt flag", 32'(halted), 32'(e_halt));
        // R10: hold without ack.
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            chk(out_valid && out_operand == e_op && out_class == e_cls && out_opc == e_opc,
                "R10", "held result", out_operand, e_op);
        end
        out_ack = 1'b1;
        @(negedge clk);
        out_ack = 1'b0;
        chk(out_valid == 1'b0, "R10", "valid after ack", 32'(out_valid), 32'd0);
        chk(in_ready == !e_halt, "R10", "ready after ack", 32'(in_ready), 32'(!e_halt));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got %h expected %h", 32'd0, 32'd1);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(in_ready == 1'b1, "R1", "in_ready", 32'(in_ready), 32'd1);
        chk(out_valid == 1'b0, "R1", "out_valid", 32'(out_valid), 32'd0);
        chk(halted == 1'b0, "R1", "halted", 32'(halted), 32'd0);
        chk(mem_rd_en == 1'b0, "R1", "mem_rd_en", 32'(mem_rd_en), 32'd0);
        // R9: nothing starts without in_valid
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!out_valid && !mem_rd_en, "R9", "idle activity",
                32'({out_valid, mem_rd_en}), 32'd0);
        end
        run_instr({3'd5, 2'b11, 27'h7ABCDEF}, "R5");   // immediate
        run_instr({3'd6, 2'b11, 27'h7FFFFFF}, "R2");   // highest two-operand opcode
        run_instr({3'd0, 2'b00, 27'h0000123}, "R6");   // direct
        index_val = 32'h0000_0100;
        run_instr({3'd3, 2'b10, 27'h0000040}, "R7");   // indexed
        index_val = 32'hFFFF_FFF0;
        run_instr({3'd1, 2'b10, 27'h0000020}, "R7");   // indexed, address wraps
        run_instr({3'd2, 2'b01, 27'h0000055}, "R8");   // indirect
        run_instr({4'hE, 3'd4, 25'h1ABCDE}, "R3");     // one-operand, bits 28:27 look indirect
        run_instr({4'hE, 3'd7, 25'h1FFFFFF}, "R3");    // one-operand, full field
        run_instr(32'hF000_0005, "R4");                // no-operand, no halt
        run_instr(32'hF200_0000, "R4");                // no-operand opcode 1, no halt
        run_instr(32'hF000_0000, "R11");               // halt
        // R11: words offered after halt are refused
        in_word = {3'd5, 2'b11, 27'h1}; in_valid = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(!in_ready && !out_valid && !mem_rd_en && halted, "R11", "after halt",
                32'({in_ready, out_valid, mem_rd_en, halted}), 32'h1);
        end
        in_valid = 1'b0;
        done = 1;
        finish_run();
    end
endmodule